// File: doc/BRIEF.md
# Keyed Substitution-Permutation Diffuser

This block is a purely combinational keyed substitution-permutation network whose word width and round count are parameters. A data word and a key word of the same width enter together with a direction bit; the transformed word leaves in the same cycle. It spreads every input bit over a whole memory data chunk, and it can remap a memory address non-linearly.

Each round mixes in the key, passes the state through a 4-bit S-box layer, reverses the bit order and then gathers even-indexed bits into the low half and odd-indexed bits into the high half. Reversing the bits before each gather moves leftover upper bits into nibble positions. So every bit meets an S-box sooner or later, even when the width is odd or not a multiple of four. The inverse direction undoes the forward transform exactly under the same key, so one instance can both encode and decode.

Top module: `spn_diffuser`

## Requirements
- R1: With `dir_i` = 0, each round computes state XOR key, then the S-box layer, then the bit reversal, then the gather; after the last round the key is XORed once more, and the result is `data_o`.
- R2: The S-box layer maps each complete nibble, counted from bit 0, through the table 0..F -> C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2; when the width is not a multiple of 4, the remaining upper bits leave the layer unchanged.
- R3: The bit reversal sets output bit i to input bit DATA_W-1-i.
- R4: The gather places input bits 0,2,4,... in order at positions 0,1,2,..., and input bits 1,3,5,... in order from position DATA_W/2 upward; for an odd width, bit DATA_W-1 keeps its position.
- R5: With `dir_i` = 1 the block computes the exact inverse of the forward transform under the same key: inverse(forward(x)) = x and forward(inverse(x)) = x for every x.
- R6: The defaults are DATA_W = 8 and ROUNDS = 2; with these defaults, all-zero data and an all-zero key give `data_o` = 0x00.
- R7: The block holds no state: `data_o` follows its inputs without any clock edge.
- R8: Any width works, including odd widths and widths that are not multiples of 4. With DATA_W = 7, ROUNDS = 2 and zero data and key, `data_o` = 0x52.
- R9: The direction bit `dir_i` selects forward when 0 and inverse when 1; changing only `dir_i` changes the function applied to the same data and key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | DATA_W | Word to transform |
| key_i | input | DATA_W | Round key, used unchanged in every round |
| dir_i | input | 1 | 0 = forward transform, 1 = inverse transform |
| data_o | output | DATA_W | Transformed word |

## Verification
The forward and inverse directions are both evaluated from the same key in every cycle. The sharpest test is a single step that changes the direction bit and the data word together. The bench feeds a forward result straight back with `dir_i` raised and expects the original word, sweeping every value at widths 8, 7 and 10. It also feeds arbitrary words into the inverse direction and runs the bench's own forward model on the result to confirm the round trip from the other side.

// File: rtl/spn_pkg.sv
package spn_pkg;

    typedef enum logic {
        SPN_FWD = 1'b0,
        SPN_INV = 1'b1
    } spn_dir_e;

    function automatic logic [3:0] spn_sbox(input logic [3:0] x);
        logic [3:0] y;
        case (x)
            4'h0: y = 4'hC;
            4'h1: y = 4'h5;
            4'h2: y = 4'h6;
            4'h3: y = 4'hB;
            4'h4: y = 4'h9;
            4'h5: y = 4'h0;
            4'h6: y = 4'hA;
            4'h7: y = 4'hD;
            4'h8: y = 4'h3;
            4'h9: y = 4'hE;
            4'hA: y = 4'hF;
            4'hB: y = 4'h8;
            4'hC: y = 4'h4;
            4'hD: y = 4'h7;
            4'hE: y = 4'h1;
            default: y = 4'h2;
        endcase
        return y;
    endfunction

    function automatic logic [3:0] spn_sbox_inv(input logic [3:0] x);
        logic [3:0] y;
        case (x)
            4'h0: y = 4'h5;
            4'h1: y = 4'hE;
            4'h2: y = 4'hF;
            4'h3: y = 4'h8;
            4'h4: y = 4'hC;
            4'h5: y = 4'h1;
            4'h6: y = 4'h2;
            4'h7: y = 4'hD;
            4'h8: y = 4'hB;
            4'h9: y = 4'h4;
            4'hA: y = 4'h6;
            4'hB: y = 4'h3;
            4'hC: y = 4'h0;
            4'hD: y = 4'h7;
            4'hE: y = 4'h9;
            default: y = 4'hA;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/spn_sub_layer.sv
module spn_sub_layer
    import spn_pkg::*;
#(
    parameter int W   = 8,
    parameter bit INV = 1'b0
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o
);
    localparam int NNIB = W / 4;
    localparam int TAIL = W - 4 * NNIB;

    for (genvar n = 0; n < NNIB; n++) begin : g_nib
        if (INV) begin : g_inv
            assign y_o[n*4 +: 4] = spn_sbox_inv(x_i[n*4 +: 4]);
            always_comb begin
                // R2: the forward table must undo this nibble
                a_r2_nibble_inv: assert (spn_sbox(y_o[n*4 +: 4]) == x_i[n*4 +: 4]);
            end
        end else begin : g_fwd
            assign y_o[n*4 +: 4] = spn_sbox(x_i[n*4 +: 4]);
            always_comb begin
                // R2: the inverse table must recover the nibble
                a_r2_nibble_fwd: assert (spn_sbox_inv(y_o[n*4 +: 4]) == x_i[n*4 +: 4]);
            end
        end
    end

    if (TAIL > 0) begin : g_tail
        assign y_o[W-1 -: TAIL] = x_i[W-1 -: TAIL];
    end
endmodule

// File: rtl/spn_flip.sv
module spn_flip #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y_o[i] = x_i[W-1-i];
    end

    always_comb begin
        // R3: reversal moves bits, never creates or drops them
        a_r3_flip_weight: assert ($countones(y_o) == $countones(x_i));
    end
endmodule

// File: rtl/spn_gather.sv
module spn_gather #(
    parameter int W   = 8,
    parameter bit INV = 1'b0
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o
);
    localparam int HALF = W / 2;
    localparam bit ODD  = (W % 2) != 0;

    for (genvar i = 0; i < HALF; i++) begin : g_pair
        if (INV) begin : g_inv
            assign y_o[2*i]   = x_i[i];
            assign y_o[2*i+1] = x_i[i+HALF];
        end else begin : g_fwd
            assign y_o[i]      = x_i[2*i];
            assign y_o[i+HALF] = x_i[2*i+1];
        end
    end

    if (ODD) begin : g_top
        assign y_o[W-1] = x_i[W-1];
    end

    always_comb begin
        // R4: the gather is a pure bit permutation
        a_r4_gather_weight: assert ($countones(y_o) == $countones(x_i));
    end
endmodule

// File: rtl/spn_round.sv
module spn_round #(
    parameter int W   = 8,
    parameter bit INV = 1'b0
) (
    input  logic [W-1:0] st_i,
    input  logic [W-1:0] key_i,
    output logic [W-1:0] st_o
);
    logic [W-1:0] s_a, s_b, s_c;

    if (!INV) begin : g_fwd
        assign s_a = st_i ^ key_i;
        spn_sub_layer #(.W(W), .INV(1'b0)) u_sub  (.x_i(s_a), .y_o(s_b));
        spn_flip      #(.W(W))             u_flip (.x_i(s_b), .y_o(s_c));
        spn_gather    #(.W(W), .INV(1'b0)) u_gth  (.x_i(s_c), .y_o(st_o));
    end else begin : g_inv
        spn_gather    #(.W(W), .INV(1'b1)) u_gth  (.x_i(st_i), .y_o(s_a));
        spn_flip      #(.W(W))             u_flip (.x_i(s_a),  .y_o(s_b));
        spn_sub_layer #(.W(W), .INV(1'b1)) u_sub  (.x_i(s_b),  .y_o(s_c));
        assign st_o = s_c ^ key_i;
    end
endmodule

// File: rtl/spn_diffuser.sv
module spn_diffuser
    import spn_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ROUNDS = 2
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] key_i,
    input  logic              dir_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int NST = ROUNDS + 1;

    spn_dir_e          dir;
    logic [DATA_W-1:0] fwd_st [NST];
    logic [DATA_W-1:0] inv_st [NST];

    assign dir       = spn_dir_e'(dir_i);
    assign fwd_st[0] = data_i;
    assign inv_st[0] = data_i ^ key_i;

    for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
        spn_round #(.W(DATA_W), .INV(1'b0)) u_fwd (
            .st_i (fwd_st[r]),
            .key_i(key_i),
            .st_o (fwd_st[r+1])
        );
        spn_round #(.W(DATA_W), .INV(1'b1)) u_inv (
            .st_i (inv_st[r]),
            .key_i(key_i),
            .st_o (inv_st[r+1])
        );
    end

    assign data_o = (dir == SPN_INV) ? inv_st[ROUNDS] : (fwd_st[ROUNDS] ^ key_i);
endmodule

// File: tb/sim_spn_diffuser.sv
`timescale 1ns/1ps
module sim_spn_diffuser;
    localparam real HALF_NS = 2.5;
    localparam int  RND     = 2;
    localparam logic [3:0] SB [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                       4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(HALF_NS) clk = ~clk;

    logic [7:0] d8 = '0, k8 = '0, o8;
    logic [6:0] d7 = '0, k7 = '0, o7;
    logic [9:0] d10 = '0, k10 = '0, o10;
    logic m8 = 1'b0, m7 = 1'b0, m10 = 1'b0;

    spn_diffuser #(.DATA_W(8),  .ROUNDS(RND)) u0 (.data_i(d8),  .key_i(k8),  .dir_i(m8),  .data_o(o8));
    spn_diffuser #(.DATA_W(7),  .ROUNDS(RND)) u1 (.data_i(d7),  .key_i(k7),  .dir_i(m7),  .data_o(o7));
    spn_diffuser #(.DATA_W(10), .ROUNDS(RND)) u2 (.data_i(d10), .key_i(k10), .dir_i(m10), .data_o(o10));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    function automatic logic [15:0] wmask(input int w);
        return 16'((32'd1 << w) - 1);
    endfunction

    // Bench model of the forward transform, written from R1..R4
    function automatic logic [15:0] ref_fwd(input int w, input logic [15:0] d, input logic [15:0] k);
        logic [15:0] s, t, km;
        km = k & wmask(w);
        s  = d & wmask(w);
        for (int r = 0; r < RND; r++) begin
            s ^= km;
            for (int n = 0; n < w / 4; n++) s[n*4 +: 4] = SB[s[n*4 +: 4]];
            t = s;
            for (int i = 0; i < w; i++) t[i] = s[w-1-i];
            s = t;
            for (int i = 0; i < w / 2; i++) begin
                t[i]       = s[2*i];
                t[i + w/2] = s[2*i+1];
            end
            s = t;
        end
        return (s ^ km) & wmask(w);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int w, input logic [15:0] d, input logic [15:0] k, input logic dir);
        case (w)
            8:       begin d8  = d[7:0]; k8  = k[7:0]; m8  = dir; end
            7:       begin d7  = d[6:0]; k7  = k[6:0]; m7  = dir; end
            default: begin d10 = d[9:0]; k10 = k[9:0]; m10 = dir; end
        endcase
    endtask

    function automatic logic [15:0] read(input int w);
        case (w)
            8:       return {8'b0, o8};
            7:       return {9'b0, o7};
            default: return {6'b0, o10};
        endcase
    endfunction

    task automatic apply(input int w, input logic [15:0] d, input logic [15:0] k,
                         input logic dir, output logic [15:0] q);
        @(posedge clk);
        #1;
        drive(w, d, k, dir);
        @(negedge clk);
        q = read(w);
    endtask

    // R6: defaults with zero inputs while reset is held
    task automatic t_reset_state();
        @(negedge clk);
        check("R6 zero in, zero key", read(8), 16'h00);
    endtask

    // R8, R2, R4: hand-computed odd width answer
    task automatic t_odd_known();
        logic [15:0] q;
        apply(7, 16'h0, 16'h0, 1'b0, q);
        check("R8 width 7 zero vector", q, 16'h52);
    endtask

    // R1, R2, R3, R4: forward sweep against the bench model
    task automatic t_fwd_sweep(input int w, input logic [15:0] k);
        logic [15:0] q;
        for (int v = 0; v < (1 << w); v++) begin
            apply(w, 16'(v), k, 1'b0, q);
            check("R1 forward model", q, ref_fwd(w, 16'(v), k));
        end
    endtask

    // R5, R9: forward result fed back with the direction bit raised in the same step
    task automatic t_roundtrip(input int w, input logic [15:0] k);
        logic [15:0] y, z;
        for (int v = 0; v < (1 << w); v++) begin
            apply(w, 16'(v), k, 1'b0, y);
            apply(w, y, k, 1'b1, z);
            check("R5 inverse(forward(x))", z, 16'(v));
        end
    endtask

    // R5: inverse output must map back through the bench forward model
    task automatic t_inv_model(input int w, input logic [15:0] k);
        logic [15:0] q;
        for (int v = 0; v < (1 << w); v += 3) begin
            apply(w, 16'(v), k, 1'b1, q);
            check("R5 forward(inverse(x))", ref_fwd(w, q, k), 16'(v));
        end
    endtask

    // R7, R9: output follows inputs between edges; direction alone changes the function
    task automatic t_comb_dir();
        @(posedge clk);
        #1;
        drive(8, 16'hA7, 16'h3C, 1'b0);
        #0.5;
        check("R7 follows input, no edge", read(8), ref_fwd(8, 16'hA7, 16'h3C));
        drive(8, 16'h5E, 16'h3C, 1'b0);
        #0.5;
        check("R7 new data, no edge", read(8), ref_fwd(8, 16'h5E, 16'h3C));
        m8 = 1'b1;
        #0.5;
        check("R9 direction bit selects inverse", ref_fwd(8, read(8), 16'h3C), 16'h5E);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        @(posedge clk);
        rst = 1'b0;
        t_odd_known();
        t_fwd_sweep(8, 16'h00);
        t_fwd_sweep(8, 16'h9B);
        t_fwd_sweep(7, 16'h35);
        t_fwd_sweep(10, 16'h2D6);
        t_roundtrip(8, 16'h6E);
        t_roundtrip(7, 16'h4B);
        t_roundtrip(10, 16'h1F3);
        t_inv_model(8, 16'hC4);
        t_inv_model(10, 16'h0A9);
        t_comb_dir();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule